// File: doc/BRIEF.md
# Auto-Commit Multi-Buffer Packet FIFO

This block is the inbound packet store of one streaming endpoint. A producer engine pushes bytes into the current fill buffer, one byte per cycle, over a valid/ready pair. The store holds a small ring of packet buffers. When the byte count of the fill buffer reaches the configured packet size and auto-commit is on, the buffer is handed to the consumer in the same clock edge that wrote its last byte, and filling moves on to the next free buffer. No arming step is needed. A short packet, or a packet with no bytes at all, can also be committed on request.

The consumer side is a plain valid/ready drain. It shows the oldest committed packet byte by byte, marks the final byte, and flags a zero-length packet as a single beat. Packets leave in commit order.

A byte-wide control register sets or clears a global flag that hides all data from the consumer. The same register clears this endpoint's buffers. Writes to the register that come too soon after the previous accepted write are dropped.

Top module: `pktFifo`

## Requirements
- R1: After reset, consValid is 0, prodReady is 1, commitCnt and fillCount are 0, allEmpty is 1 and nakActive is 0.
- R2: With cfgAutoCommit=1, the clock edge that accepts the byte that brings the fill count to the effective packet size commits that buffer. From that edge on, fillCount reads 0 and commitCnt is one higher.
- R3: A committed packet is presented byte by byte in the order the bytes were pushed. consLast is 1 on its final byte only. While consValid=1 and consReady=0, consData and consLast hold still.
- R4: Committed packets are drained in the order they were committed, across all NUM_BUFS (default 4) buffers.
- R5: While all buffers are committed, allFull=1 and prodReady=0, and an offered byte is not stored. Draining one packet restores prodReady=1.
- R6: A pulse on commitReq commits the fill buffer with its current count. With count 0, the commit happens only when cfgZlpEn=1. The resulting empty packet drains as one beat with consValid, consLast and consZero all 1.
- R7: With cfgAutoCommit=0, no commit happens at the packet size. The producer is stalled (prodReady=0) once the buffer holds MAX_PKT (default 64) bytes, until commitReq.
- R8: A cfgPktSize of 0, or one above MAX_PKT, is treated as MAX_PKT.
- R9: An accepted control write with bit 7 set raises nakActive. An accepted write of 0x00 clears it. While nakActive=1, consValid is 0 and no byte is removed, whatever consReady does.
- R10: An accepted control write with bit 7 clear, bits 6:4 zero and bits 3:0 equal to EP_CODE (default 2) empties all buffers and clears all byte counts. Other endpoint codes (for example 0x04, 0x06, 0x08) leave the FIFO untouched.
- R11: A control write is accepted only if at least MIN_GAP (default 3) cycles have passed since the previous accepted write. Earlier writes are ignored and do not restart the spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAutoCommit | input | 1 | Commit a buffer automatically at the packet size |
| cfgZlpEn | input | 1 | Allow commit requests with zero bytes |
| cfgPktSize | input | 7 | Packet size in bytes (0 or above MAX_PKT means MAX_PKT) |
| prodValid | input | 1 | Producer offers a byte |
| prodData | input | 8 | Producer byte |
| prodReady | output | 1 | Fill buffer has space; producer may push |
| commitReq | input | 1 | Commit the fill buffer now (short or empty packet) |
| rstRegWr | input | 1 | Control register write strobe |
| rstRegData | input | 8 | Control register write value |
| consValid | output | 1 | A committed byte or empty packet is presented |
| consReady | input | 1 | Consumer takes the presented beat |
| consData | output | 8 | Presented byte |
| consLast | output | 1 | Final beat of the presented packet |
| consZero | output | 1 | Presented packet has zero length |
| fillCount | output | 7 | Bytes in the current fill buffer |
| commitCnt | output | 3 | Number of committed, undrained packets |
| allFull | output | 1 | Every buffer is committed |
| allEmpty | output | 1 | No committed packet and an empty fill buffer |
| nakActive | output | 1 | Global data-hiding flag is set |

## Verification
The bench pushes byte counts that land exactly on, below and across the packet size. A design that commits one byte late or early would leave a nonzero fillCount or mark the wrong byte as last. It fills every buffer and then offers one extra byte: a design that overwrote a committed buffer would corrupt the last packet drained. It holds consReady high while data is hidden: a leaky flag would lose the first byte. It issues control writes back to back, writes codes for other endpoints, and makes a zero-byte commit with the enable on and off. These catch designs that skip the spacing rule, decode the endpoint code loosely, or emit empty packets unasked.

// File: rtl/pktFifoPkg.sv
package pktFifoPkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic wrEn;      // store producer byte
    logic commitEn;  // latch the length of the fill buffer
    logic clearAll;  // endpoint reset: zero every length
  } dpStrobe_t;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_NAK_SET,
    REG_NAK_CLR,
    REG_EP_RESET
  } regCmd_e;

  function automatic regCmd_e decodeReg(input logic [7:0] v, input logic [3:0] ep);
    regCmd_e c;
    if (v[7]) c = REG_NAK_SET;
    else if (v == 8'h00) c = REG_NAK_CLR;
    else if (v[6:4] == 3'd0 && v[3:0] == ep) c = REG_EP_RESET;
    else c = REG_NONE;
    return c;
  endfunction

endpackage

// File: rtl/pktFifoData.sv
module pktFifoData
  import pktFifoPkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int DATA_W   = 8,
  parameter int MAX_PKT  = 64,
  localparam int BUF_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
  localparam int LEN_W   = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BUF_W-1:0]  wrBuf,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BUF_W-1:0]  commitBuf,
  input  logic [LEN_W-1:0]  commitLen,
  input  logic [BUF_W-1:0]  rdBuf,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [LEN_W-1:0]  rdLen
);

  logic [DATA_W-1:0] store [NUM_BUFS][MAX_PKT];
  logic [NUM_BUFS-1:0][LEN_W-1:0] lenAll;

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrBuf][wrIdx] <= wrData;
  end

  // One length register per packet buffer
  for (genvar b = 0; b < NUM_BUFS; b++) begin : gLen
    logic [LEN_W-1:0] lenQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lenQ <= '0;
      else if (strb.clearAll) lenQ <= '0;
      else if (strb.commitEn && commitBuf == BUF_W'(b)) lenQ <= commitLen;
    end
    assign lenAll[b] = lenQ;
  end

  assign rdLen  = lenAll[rdBuf];
  assign rdData = store[rdBuf][rdIdx];

endmodule

// File: rtl/pktFifoCtrl.sv
module pktFifoCtrl
  import pktFifoPkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int MAX_PKT  = 64,
  parameter int EP_CODE  = 2,
  parameter int MIN_GAP  = 3,
  localparam int BUF_W   = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int IDX_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
  localparam int LEN_W   = $clog2(MAX_PKT + 1),
  localparam int CNT_W   = $clog2(NUM_BUFS + 1),
  localparam int GAP_W   = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgAutoCommit,
  input  logic             cfgZlpEn,
  input  logic [LEN_W-1:0] cfgPktSize,
  input  logic             prodValid,
  output logic             prodReady,
  input  logic             commitReq,
  input  logic             rstRegWr,
  input  logic [7:0]       rstRegData,
  input  logic             consReady,
  output logic             consValid,
  output logic             consLast,
  output logic             consZero,
  output logic [LEN_W-1:0] fillCount,
  output logic [CNT_W-1:0] commitCnt,
  output logic             allFull,
  output logic             allEmpty,
  output logic             nakActive,
  output dpStrobe_t        strb,
  output logic [BUF_W-1:0] wrBuf,
  output logic [IDX_W-1:0] wrIdx,
  output logic [BUF_W-1:0] commitBuf,
  output logic [LEN_W-1:0] commitLen,
  output logic [BUF_W-1:0] rdBuf,
  output logic [IDX_W-1:0] rdIdx,
  input  logic [LEN_W-1:0] rdLen
);

  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_PKT);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_BUFS);

  logic [BUF_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] used;
  logic [LEN_W-1:0] fillCnt;
  logic [IDX_W-1:0] rdPos;
  logic             nakQ;
  logic [GAP_W-1:0] gapQ;

  logic [LEN_W-1:0] effSize, fillNext;
  logic             spaceOk, push, autoHit, manHit, commitNow;
  logic             beat, lastBeat, regAccept, epReset;
  regCmd_e          cmd;

  function automatic logic [BUF_W-1:0] nextBuf(input logic [BUF_W-1:0] p);
    return (p == BUF_W'(NUM_BUFS - 1)) ? '0 : p + 1'b1;
  endfunction

  // Packet size sanitising: 0 or oversize means a full buffer
  always_comb begin
    if (cfgPktSize == '0 || cfgPktSize > MAX_LEN) effSize = MAX_LEN;
    else effSize = cfgPktSize;
  end

  // Producer side
  assign spaceOk   = (used != FULL_CNT) && (fillCnt != MAX_LEN);
  assign push      = prodValid && spaceOk;
  assign fillNext  = fillCnt + LEN_W'(push);
  assign autoHit   = cfgAutoCommit && push && (fillNext >= effSize);
  assign manHit    = commitReq && (used != FULL_CNT) && ((fillNext != '0) || cfgZlpEn);
  assign commitNow = autoHit || manHit;

  // Consumer side
  assign consValid = (used != '0) && !nakQ;
  assign consZero  = (rdLen == '0);
  assign lastBeat  = consZero || ((LEN_W'(rdPos) + LEN_W'(1)) == rdLen);
  assign beat      = consValid && consReady;

  // Control register decode with write spacing
  assign regAccept = rstRegWr && (gapQ == '0);
  assign cmd       = decodeReg(rstRegData, 4'(EP_CODE));
  assign epReset   = regAccept && (cmd == REG_EP_RESET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      used    <= '0;
      fillCnt <= '0;
      rdPos   <= '0;
    end else if (epReset) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      used    <= '0;
      fillCnt <= '0;
      rdPos   <= '0;
    end else begin
      if (commitNow) begin
        wrPtr   <= nextBuf(wrPtr);
        fillCnt <= '0;
      end else if (push) begin
        fillCnt <= fillNext;
      end
      if (beat) begin
        if (lastBeat) begin
          rdPtr <= nextBuf(rdPtr);
          rdPos <= '0;
        end else begin
          rdPos <= rdPos + 1'b1;
        end
      end
      used <= used + CNT_W'(commitNow) - CNT_W'(beat && lastBeat);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nakQ <= 1'b0;
      gapQ <= '0;
    end else begin
      if (regAccept) gapQ <= GAP_W'(MIN_GAP - 1);
      else if (gapQ != '0) gapQ <= gapQ - 1'b1;
      if (regAccept && cmd == REG_NAK_SET) nakQ <= 1'b1;
      else if (regAccept && cmd == REG_NAK_CLR) nakQ <= 1'b0;
    end
  end

  // Strobes and addressing for the datapath
  always_comb begin
    strb.wrEn     = push && !epReset;
    strb.commitEn = commitNow && !epReset;
    strb.clearAll = epReset;
  end

  assign wrBuf     = wrPtr;
  assign wrIdx     = fillCnt[IDX_W-1:0];
  assign commitBuf = wrPtr;
  assign commitLen = fillNext;
  assign rdBuf     = rdPtr;
  assign rdIdx     = rdPos;

  assign prodReady = spaceOk;
  assign consLast  = lastBeat;
  assign fillCount = fillCnt;
  assign commitCnt = used;
  assign allFull   = (used == FULL_CNT);
  assign allEmpty  = (used == '0) && (fillCnt == '0);
  assign nakActive = nakQ;

endmodule

// File: rtl/pktFifo.sv
module pktFifo
  import pktFifoPkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int DATA_W   = 8,
  parameter int MAX_PKT  = 64,
  parameter int EP_CODE  = 2,
  parameter int MIN_GAP  = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             cfgAutoCommit,
  input  logic                             cfgZlpEn,
  input  logic [$clog2(MAX_PKT+1)-1:0]     cfgPktSize,
  input  logic                             prodValid,
  input  logic [DATA_W-1:0]                prodData,
  output logic                             prodReady,
  input  logic                             commitReq,
  input  logic                             rstRegWr,
  input  logic [7:0]                       rstRegData,
  output logic                             consValid,
  input  logic                             consReady,
  output logic [DATA_W-1:0]                consData,
  output logic                             consLast,
  output logic                             consZero,
  output logic [$clog2(MAX_PKT+1)-1:0]     fillCount,
  output logic [$clog2(NUM_BUFS+1)-1:0]    commitCnt,
  output logic                             allFull,
  output logic                             allEmpty,
  output logic                             nakActive
);

  localparam int BUF_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
  localparam int IDX_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1;
  localparam int LEN_W = $clog2(MAX_PKT + 1);

  dpStrobe_t        strb;
  logic [BUF_W-1:0] wrBuf, commitBuf, rdBuf;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [LEN_W-1:0] commitLen, rdLen;

  pktFifoCtrl #(
    .NUM_BUFS(NUM_BUFS), .MAX_PKT(MAX_PKT), .EP_CODE(EP_CODE), .MIN_GAP(MIN_GAP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgAutoCommit(cfgAutoCommit), .cfgZlpEn(cfgZlpEn), .cfgPktSize(cfgPktSize),
    .prodValid(prodValid), .prodReady(prodReady), .commitReq(commitReq),
    .rstRegWr(rstRegWr), .rstRegData(rstRegData),
    .consReady(consReady), .consValid(consValid), .consLast(consLast), .consZero(consZero),
    .fillCount(fillCount), .commitCnt(commitCnt), .allFull(allFull), .allEmpty(allEmpty),
    .nakActive(nakActive),
    .strb(strb), .wrBuf(wrBuf), .wrIdx(wrIdx), .commitBuf(commitBuf), .commitLen(commitLen),
    .rdBuf(rdBuf), .rdIdx(rdIdx), .rdLen(rdLen)
  );

  pktFifoData #(
    .NUM_BUFS(NUM_BUFS), .DATA_W(DATA_W), .MAX_PKT(MAX_PKT)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrBuf(wrBuf), .wrIdx(wrIdx), .wrData(prodData),
    .commitBuf(commitBuf), .commitLen(commitLen),
    .rdBuf(rdBuf), .rdIdx(rdIdx), .rdData(consData), .rdLen(rdLen)
  );

endmodule

// File: rtl/pktFifoChk.sv
module pktFifoChk #(
  parameter int NUM_BUFS = 4,
  parameter int DATA_W   = 8,
  parameter int MAX_PKT  = 64
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          prodReady,
  input logic                          rstRegWr,
  input logic                          consValid,
  input logic                          consReady,
  input logic [DATA_W-1:0]             consData,
  input logic                          consLast,
  input logic                          consZero,
  input logic [$clog2(MAX_PKT+1)-1:0]  fillCount,
  input logic [$clog2(NUM_BUFS+1)-1:0] commitCnt,
  input logic                          allFull,
  input logic                          nakActive
);

  // R5
  commit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitCnt <= ($clog2(NUM_BUFS+1))'(NUM_BUFS));

  // R5
  full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    allFull |-> !prodReady);

  // R9
  nak_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    nakActive |-> !consValid);

  // R3
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (consValid && !consReady && !rstRegWr) |=> (consValid && $stable(consData) && $stable(consLast)));

  // R6
  zero_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (consValid && consZero) |-> consLast);

  // R4
  valid_has_pkt_chk: assert property (@(posedge clk) disable iff (!rstN)
    consValid |-> (commitCnt != '0));

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= ($clog2(MAX_PKT+1))'(MAX_PKT));

endmodule

bind pktFifo pktFifoChk #(
  .NUM_BUFS(NUM_BUFS), .DATA_W(DATA_W), .MAX_PKT(MAX_PKT)
) chk_i (.*);

// File: tb/pktFifo_tb.sv
`timescale 1ns/1ps
module pktFifo_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgAutoCommit = 1'b1;
  logic       cfgZlpEn = 1'b0;
  logic [6:0] cfgPktSize = 7'd4;
  logic       prodValid = 1'b0;
  logic [7:0] prodData = 8'h00;
  logic       commitReq = 1'b0;
  logic       rstRegWr = 1'b0;
  logic [7:0] rstRegData = 8'h00;
  logic       consReady = 1'b0;
  logic       prodReady, consValid, consLast, consZero, allFull, allEmpty, nakActive;
  logic [7:0] consData;
  logic [6:0] fillCount;
  logic [2:0] commitCnt;

  int checks = 0;
  int failures = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  pktFifo dut_i (
    .clk(clk), .rstN(rstN), .cfgAutoCommit(cfgAutoCommit), .cfgZlpEn(cfgZlpEn),
    .cfgPktSize(cfgPktSize), .prodValid(prodValid), .prodData(prodData),
    .prodReady(prodReady), .commitReq(commitReq), .rstRegWr(rstRegWr),
    .rstRegData(rstRegData), .consValid(consValid), .consReady(consReady),
    .consData(consData), .consLast(consLast), .consZero(consZero),
    .fillCount(fillCount), .commitCnt(commitCnt), .allFull(allFull),
    .allEmpty(allEmpty), .nakActive(nakActive)
  );

  // {pktSize[6:0], nBytes[8:0], seed[7:0], expPkts[7:0]}
  localparam logic [31:0] VECS [6] = '{
    {7'd4,   9'd10, 8'h10, 8'd3},
    {7'd8,   9'd32, 8'h40, 8'd4},
    {7'd1,   9'd3,  8'hA0, 8'd3},
    {7'd0,   9'd64, 8'h00, 8'd1},
    {7'd100, 9'd70, 8'h20, 8'd2},
    {7'd16,  9'd20, 8'h77, 8'd2}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pushBytes(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prodValid = 1'b1;
      prodData  = 8'(seed + 8'(i));
    end
    @(negedge clk);
    prodValid = 1'b0;
  endtask

  task automatic doCommit();
    @(negedge clk);
    commitReq = 1'b1;
    @(negedge clk);
    commitReq = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk);
    rstRegWr   = 1'b1;
    rstRegData = v;
    @(negedge clk);
    rstRegWr   = 1'b0;
  endtask

  task automatic drainPkt(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk("R3 beat valid", int'(consValid), 1);
      chk("R3 byte order", int'(consData), int'(8'(seed + 8'(i))));
      chk("R3 last marker", int'(consLast), (i == len - 1) ? 1 : 0);
      consReady = 1'b1;
    end
    @(negedge clk);
    consReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 consValid", int'(consValid), 0);
    chk("R1 prodReady", int'(prodReady), 1);
    chk("R1 commitCnt", int'(commitCnt), 0);
    chk("R1 fillCount", int'(fillCount), 0);
    chk("R1 allEmpty", int'(allEmpty), 1);
    chk("R1 nakActive", int'(nakActive), 0);

    // Vector walk: R2 auto-commit, R4 ordering, R8 size sanitising
    foreach (VECS[v]) begin
      int size, n, eff, full, rem, pkts;
      logic [7:0] seed;
      size = int'(VECS[v][31:25]);
      n    = int'(VECS[v][24:16]);
      seed = VECS[v][15:8];
      pkts = int'(VECS[v][7:0]);
      eff  = (size == 0 || size > 64) ? 64 : size;
      full = n / eff;
      rem  = n % eff;
      cfgAutoCommit = 1'b1;
      cfgPktSize = 7'(size);
      pushBytes(n, seed);
      chk("R2 R8 commit count after push", int'(commitCnt), full);
      chk("R2 R8 fill remainder", int'(fillCount), rem);
      if (rem != 0) doCommit();
      chk("R4 packets queued", int'(commitCnt), pkts);
      for (int p = 0; p < pkts; p++)
        drainPkt((p < full) ? eff : rem, 8'(seed + 8'(p * eff)));
      chk("R4 all drained", int'(allEmpty), 1);
    end

    // R5 all buffers committed
    cfgPktSize = 7'd2;
    pushBytes(8, 8'h50);
    chk("R5 allFull", int'(allFull), 1);
    chk("R5 prodReady low", int'(prodReady), 0);
    pushBytes(1, 8'hEE);
    chk("R5 extra byte dropped fill", int'(fillCount), 0);
    chk("R5 extra byte dropped count", int'(commitCnt), 4);
    drainPkt(2, 8'h50);
    chk("R5 space restored", int'(prodReady), 1);
    chk("R5 allFull cleared", int'(allFull), 0);
    drainPkt(2, 8'h52);
    drainPkt(2, 8'h54);
    drainPkt(2, 8'h56);
    chk("R5 empty after", int'(allEmpty), 1);

    // R6 zero-length packets
    cfgZlpEn = 1'b1;
    doCommit();
    chk("R6 zlp committed", int'(commitCnt), 1);
    chk("R6 zlp valid", int'(consValid), 1);
    chk("R6 zlp zero flag", int'(consZero), 1);
    chk("R6 zlp last", int'(consLast), 1);
    consReady = 1'b1;
    @(negedge clk);
    consReady = 1'b0;
    chk("R6 zlp one beat", int'(commitCnt), 0);
    cfgZlpEn = 1'b0;
    doCommit();
    chk("R6 zlp disabled", int'(commitCnt), 0);
    chk("R6 zlp disabled valid", int'(consValid), 0);

    // R7 manual mode
    cfgAutoCommit = 1'b0;
    cfgPktSize = 7'd4;
    pushBytes(64, 8'h00);
    chk("R7 no auto commit", int'(commitCnt), 0);
    chk("R7 fill at capacity", int'(fillCount), 64);
    chk("R7 producer stalled", int'(prodReady), 0);
    doCommit();
    chk("R7 manual commit", int'(commitCnt), 1);
    chk("R7 fill cleared", int'(fillCount), 0);
    drainPkt(64, 8'h00);
    cfgAutoCommit = 1'b1;

    // R9 NAK-all hides data
    cfgPktSize = 7'd2;
    pushBytes(2, 8'h90);
    wrReg(8'h80);
    idle(3);
    chk("R9 nak set", int'(nakActive), 1);
    chk("R9 valid hidden", int'(consValid), 0);
    @(negedge clk);
    consReady = 1'b1;
    idle(4);
    consReady = 1'b0;
    chk("R9 nothing removed", int'(commitCnt), 1);
    wrReg(8'h00);
    chk("R9 nak cleared", int'(nakActive), 0);
    chk("R9 data visible", int'(consValid), 1);
    chk("R9 first byte kept", int'(consData), 8'h90);
    drainPkt(2, 8'h90);
    idle(3);

    // R11 write spacing
    wrReg(8'h80);
    wrReg(8'h00);
    chk("R11 early write ignored", int'(nakActive), 1);
    wrReg(8'h00);
    chk("R11 spaced write taken", int'(nakActive), 0);
    idle(3);

    // R10 endpoint reset
    pushBytes(5, 8'hB0);
    chk("R10 setup count", int'(commitCnt), 2);
    wrReg(8'h04);
    chk("R10 other ep count", int'(commitCnt), 2);
    chk("R10 other ep fill", int'(fillCount), 1);
    idle(3);
    wrReg(8'h06);
    idle(3);
    wrReg(8'h02);
    chk("R10 reset count", int'(commitCnt), 0);
    chk("R10 reset fill", int'(fillCount), 0);
    chk("R10 reset empty", int'(allEmpty), 1);
    chk("R10 reset no valid", int'(consValid), 0);
    chk("R10 reset ready", int'(prodReady), 1);
    idle(3);
    pushBytes(2, 8'hC0);
    drainPkt(2, 8'hC0);

    doneFlag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule